// File: doc/BRIEF.md
# Auxiliary I/O Control Register Block

A bank of small control registers that sits behind a simple memory-mapped register bus inside a workstation I/O companion device. It holds five byte-wide registers: configuration, two auxiliary registers, a diagnostic byte and a modem-control byte. It also holds a 16-bit diagnostic LED register and a 32-bit system-control register. A power-failure status flag lives inside the second auxiliary register. The flag follows a power-failing input, is gated by an enable bit in the configuration register, can be cleared by software, and drives an interrupt.

Some writes are commands and produce single-cycle request pulses for the rest of the system: a shutdown request from the second auxiliary register, a system-reset request from the system-control register, and a CPU-halt request from any write to a separate power-management address. The bus read path is combinational from the address. Writes take effect on the clock edge at which the write strobe is sampled high. The diagnostic byte, the LED register and the system-control register are not cleared by reset. This lets software read them back after a reset that the block itself requested.

Top module: `aux_ctrl_regs`

## Requirements
- R1: After synchronous reset, configuration, aux-1, aux-2 and modem-control read as zero, `irq` is low and all three request pulses are low.
- R2: Registers are selected by `bus_addr & 32'h0fff_0000`. Configuration is at 0x0180_0000, aux-1 at 0x0190_0000, aux-2 at 0x0191_0000, diagnostic at 0x01a0_0000 and modem control at 0x01b0_0000. A write to any of these except aux-2 stores `bus_wdata[7:0]`, and a read returns that byte zero-extended. Address bits outside the mask are ignored.
- R3: The LED register at 0x0160_0000 stores and returns `bus_wdata[15:0]`.
- R4: A read of an address that selects no register returns zero. A write to such an address changes no register and raises no request pulse.
- R5: When `pwr_failing` changes value, aux-2 bit 5 is loaded with the new input value ANDed with configuration bit 3. The bit changes at no other time except through R7.
- R6: `irq` is high exactly when aux-2 bit 5 and configuration bit 3 are both set.
- R7: A write to aux-2 stores `bus_wdata[1:0]` into aux-2 bits 1:0. If `bus_wdata[1]` is set, aux-2 bit 5 is cleared, and it stays clear while `pwr_failing` holds steady. All other aux-2 bits read as zero.
- R8: A write to aux-2 with `bus_wdata[0]` set raises `shutdown_req` for exactly the one cycle after the write edge.
- R9: The system-control register sits at 0x01f0_0000 and is selected only when `bus_addr[1:0]` is 0. A write with `bus_wdata[0]` set loads the value 0x0000_0002 and raises `sysreset_req` for one cycle. A write with `bus_wdata[0]` clear stores `bus_wdata`. The other three low-address offsets read as zero.
- R10: A write to the address `PM_ADDR` raises `halt_req` for one cycle, and a read of `PM_ADDR` returns zero.
- R11: The diagnostic, LED and system-control registers keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Register bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pwr_failing | input | 1 | Power-failing indication, synchronous to `clk` |
| irq | output | 1 | Power-fail interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |
| sysreset_req | output | 1 | One-cycle system-reset request |
| halt_req | output | 1 | One-cycle CPU-halt request |

## Verification
The bench focuses on the power-fail flag.

- **Clear while the input stays high.** Software clears the flag while `pwr_failing` stays high, and the bench checks that the flag stays clear. A design that tracked the input level would re-set it at once.
- **Disabling the interrupt.** The bench clears the enable bit while the flag is set. The interrupt must drop and the flag must stay set. A design that cleared the flag on a config write would lose the status.
- **Reset retention.** The bench asserts reset after loading the diagnostic, LED and system-control registers. A design that reset every register would read back zero.
- **Address decode.** The bench aliases addresses through bits outside the mask and writes to unmapped addresses and to non-zero system-control offsets with bit 0 set. This exposes decoders that compare too many bits, or that pulse on a command written to the wrong place.

// File: rtl/aux_regs_pkg.sv
package aux_regs_pkg;

    typedef logic [31:0] addr_t;

    localparam addr_t SEL_MASK    = 32'h0fff_0000;
    localparam addr_t OFS_LED     = 32'h0160_0000;
    localparam addr_t OFS_CFG     = 32'h0180_0000;
    localparam addr_t OFS_AUX1    = 32'h0190_0000;
    localparam addr_t OFS_AUX2    = 32'h0191_0000;
    localparam addr_t OFS_DIAG    = 32'h01a0_0000;
    localparam addr_t OFS_MDM     = 32'h01b0_0000;
    localparam addr_t OFS_SYS     = 32'h01f0_0000;

    localparam int CFG_PFIE_BIT   = 3;
    localparam int AUX2_OFF_BIT   = 0;
    localparam int AUX2_CLR_BIT   = 1;
    localparam int AUX2_PF_BIT    = 5;
    localparam int SYS_RST_BIT    = 0;
    localparam int SYS_STAT_VALUE = 2;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_LED,
        RG_CFG,
        RG_AUX1,
        RG_AUX2,
        RG_DIAG,
        RG_MDM,
        RG_SYS,
        RG_PM
    } region_e;

    typedef struct packed {
        logic halt;
        logic sysreset;
        logic shutdown;
    } req_t;

    localparam int NREQ = $bits(req_t);

    function automatic region_e decode_region(addr_t a, addr_t pm_addr);
        region_e r;
        addr_t   m;
        m = a & SEL_MASK;
        r = RG_NONE;
        unique case (m)
            OFS_LED:  r = RG_LED;
            OFS_CFG:  r = RG_CFG;
            OFS_AUX1: r = RG_AUX1;
            OFS_AUX2: r = RG_AUX2;
            OFS_DIAG: r = RG_DIAG;
            OFS_MDM:  r = RG_MDM;
            OFS_SYS:  r = (a[1:0] == 2'b00) ? RG_SYS : RG_NONE;
            default:  r = (a == pm_addr) ? RG_PM : RG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aux_addr_decode.sv
module aux_addr_decode
    import aux_regs_pkg::*;
#(
    parameter addr_t PM_ADDR = 32'h0a00_0000
) (
    input  addr_t   addr,
    output region_e region
);

    always_comb begin
        region = decode_region(addr, PM_ADDR);
    end

endmodule

// File: rtl/aux_pwr_status.sv
module aux_pwr_status
    import aux_regs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_failing,
    input  logic              pf_enable,
    input  logic              aux2_wr,
    input  logic [1:0]        cmd_bits,
    output logic [BYTE_W-1:0] aux2_value,
    output logic              irq
);

    logic       pf_prev;
    logic       pf_flag;
    logic [1:0] cmd_q;
    logic       input_moved;

    assign input_moved = (pwr_failing != pf_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_prev <= 1'b0;
            pf_flag <= 1'b0;
            cmd_q   <= 2'b00;
        end else begin
            pf_prev <= pwr_failing;
            if (aux2_wr) begin
                cmd_q <= cmd_bits;
                if (cmd_bits[AUX2_CLR_BIT]) begin
                    pf_flag <= 1'b0;
                end
            end
            if (input_moved) begin
                pf_flag <= pwr_failing & pf_enable;
            end
        end
    end

    always_comb begin
        aux2_value              = '0;
        aux2_value[1:0]         = cmd_q;
        aux2_value[AUX2_PF_BIT] = pf_flag;
    end

    assign irq = pf_flag & pf_enable;

endmodule

// File: rtl/aux_pulse_gen.sv
module aux_pulse_gen #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trig,
    output logic [N-1:0] pulse
);

    for (genvar i = 0; i < N; i++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (rst) begin
                pulse[i] <= 1'b0;
            end else begin
                pulse[i] <= trig[i];
            end
        end
    end

endmodule

// File: rtl/aux_ctrl_regs.sv
module aux_ctrl_regs
    import aux_regs_pkg::*;
#(
    parameter int    DATA_W  = 32,
    parameter int    BYTE_W  = 8,
    parameter int    LED_W   = 16,
    parameter addr_t PM_ADDR = 32'h0a00_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwr_failing,
    output logic              irq,
    output logic              shutdown_req,
    output logic              sysreset_req,
    output logic              halt_req
);

    localparam int BYTE_PAD = DATA_W - BYTE_W;
    localparam int LED_PAD  = DATA_W - LED_W;
    localparam logic [DATA_W-1:0] SYS_STAT = DATA_W'(SYS_STAT_VALUE);

    region_e           region;
    logic [BYTE_W-1:0] cfg_q, aux1_q, mdm_q, diag_q;
    logic [BYTE_W-1:0] aux2_value;
    logic [LED_W-1:0]  led_q;
    logic [DATA_W-1:0] sys_q;
    req_t              req_d, req_q;

    aux_addr_decode #(
        .PM_ADDR (PM_ADDR)
    ) u_dec (
        .addr   (bus_addr),
        .region (region)
    );

    // Registers cleared by reset
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            aux1_q <= '0;
            mdm_q  <= '0;
        end else if (bus_wr) begin
            case (region)
                RG_CFG:  cfg_q  <= bus_wdata[BYTE_W-1:0];
                RG_AUX1: aux1_q <= bus_wdata[BYTE_W-1:0];
                RG_MDM:  mdm_q  <= bus_wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

    // Registers that survive reset
    always_ff @(posedge clk) begin
        if (bus_wr && !rst) begin
            case (region)
                RG_DIAG: diag_q <= bus_wdata[BYTE_W-1:0];
                RG_LED:  led_q  <= bus_wdata[LED_W-1:0];
                RG_SYS:  sys_q  <= bus_wdata[SYS_RST_BIT] ? SYS_STAT : bus_wdata;
                default: ;
            endcase
        end
    end

    aux_pwr_status #(
        .BYTE_W (BYTE_W)
    ) u_pwr (
        .clk         (clk),
        .rst         (rst),
        .pwr_failing (pwr_failing),
        .pf_enable   (cfg_q[CFG_PFIE_BIT]),
        .aux2_wr     (bus_wr && region == RG_AUX2),
        .cmd_bits    (bus_wdata[1:0]),
        .aux2_value  (aux2_value),
        .irq         (irq)
    );

    always_comb begin
        req_d          = '0;
        req_d.shutdown = bus_wr && region == RG_AUX2 && bus_wdata[AUX2_OFF_BIT];
        req_d.sysreset = bus_wr && region == RG_SYS && bus_wdata[SYS_RST_BIT];
        req_d.halt     = bus_wr && region == RG_PM;
    end

    aux_pulse_gen #(
        .N (NREQ)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .trig  (req_d),
        .pulse (req_q)
    );

    assign shutdown_req = req_q.shutdown;
    assign sysreset_req = req_q.sysreset;
    assign halt_req     = req_q.halt;

    always_comb begin
        case (region)
            RG_CFG:  bus_rdata = {{BYTE_PAD{1'b0}}, cfg_q};
            RG_AUX1: bus_rdata = {{BYTE_PAD{1'b0}}, aux1_q};
            RG_AUX2: bus_rdata = {{BYTE_PAD{1'b0}}, aux2_value};
            RG_DIAG: bus_rdata = {{BYTE_PAD{1'b0}}, diag_q};
            RG_MDM:  bus_rdata = {{BYTE_PAD{1'b0}}, mdm_q};
            RG_LED:  bus_rdata = {{LED_PAD{1'b0}}, led_q};
            RG_SYS:  bus_rdata = sys_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/aux_ctrl_regs_chk.sv
module aux_ctrl_regs_chk
    import aux_regs_pkg::*;
#(
    parameter int    DATA_W  = 32,
    parameter addr_t PM_ADDR = 32'h0a00_0000
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              pwr_failing,
    input logic              irq,
    input logic              shutdown_req,
    input logic              sysreset_req,
    input logic              halt_req
);

    // R1: the first cycle out of reset carries no request
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(shutdown_req || sysreset_req || halt_req));

    // R4: one bus write selects one register, so at most one request
    a_r4_single_request: assert property (@(posedge clk) disable iff (rst)
        $onehot0({shutdown_req, sysreset_req, halt_req}));

    // R6: the interrupt only rises after an input change or a bus write
    a_r6_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(pwr_failing) != $past(pwr_failing, 2) || $past(bus_wr)));

    // R8: shutdown follows a write carrying the power-off bit
    a_r8_shutdown_cause: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(bus_wr && bus_wdata[0]
                               && (bus_addr & SEL_MASK) == OFS_AUX2));

    // R9: system reset follows a write to offset zero with bit 0 set
    a_r9_sysreset_cause: assert property (@(posedge clk) disable iff (rst)
        sysreset_req |-> $past(bus_wr && bus_wdata[0] && bus_addr[1:0] == 2'b00
                               && (bus_addr & SEL_MASK) == OFS_SYS));

    // R10: halt follows a write to the power-management address
    a_r10_halt_cause: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> $past(bus_wr && bus_addr == PM_ADDR));

endmodule

bind aux_ctrl_regs aux_ctrl_regs_chk #(
    .DATA_W  (DATA_W),
    .PM_ADDR (PM_ADDR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .pwr_failing  (pwr_failing),
    .irq          (irq),
    .shutdown_req (shutdown_req),
    .sysreset_req (sysreset_req),
    .halt_req     (halt_req)
);

// File: tb/aux_ctrl_regs_bench.sv
module aux_ctrl_regs_bench;

    localparam logic [31:0] PM = 32'h0a00_0000;
    localparam int NV = 20;

    // write flag, address, data, expected read data, requirement number
    localparam logic        V_WR  [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 0,
                                           1, 0, 0, 0, 0, 1, 0};
    localparam logic [31:0] V_AD  [NV] = '{
        32'h0180_0000, 32'h0180_0000,  // R2 config
        32'h0190_0000, 32'h0190_0000,  // R2 aux1
        32'h01b0_0000, 32'h01b0_0000,  // R2 modem
        32'h01a0_0000, 32'h01a0_0000,  // R2 diag
        32'h0160_0000, 32'h0160_0000,  // R3 led
        32'h01f0_0000, 32'h01f0_0000,  // R9 sys store
        32'h01f0_0001,                 // R9 sub offset
        32'h0170_0000, 32'h0170_0000,  // R4 unmapped
        32'h3180_0007,                 // R2 alias
        PM,                            // R10 read
        32'h0190_0000,                 // R4 aux1 untouched
        32'h0191_0000, 32'h0191_0000   // R7 aux2 upper bits dropped
    };
    localparam logic [31:0] V_DA  [NV] = '{
        32'hABCD_1234, 0, 32'h1FF, 0, 32'h77, 0, 32'hC3, 0,
        32'h1234_5678, 0, 32'hF0, 0, 0, 32'hFF, 0, 0, 0, 0, 32'hFC, 0};
    localparam logic [31:0] V_EX  [NV] = '{
        0, 32'h34, 0, 32'hFF, 0, 32'h77, 0, 32'hC3, 0, 32'h5678,
        0, 32'hF0, 0, 0, 0, 32'h34, 0, 32'hFF, 0, 0};
    localparam int          V_RQ  [NV] = '{2, 2, 2, 2, 2, 2, 2, 2, 3, 3,
                                           9, 9, 9, 4, 4, 2, 10, 4, 7, 7};

    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        pwr_failing = 0;
    logic        irq, shutdown_req, sysreset_req, halt_req;
    int          checks = 0;
    int          errors = 0;
    logic        done = 0;

    always #5 clk = ~clk;

    aux_ctrl_regs #(.PM_ADDR(PM)) u_aux_ctrl_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pwr_failing  (pwr_failing),
        .irq          (irq),
        .shutdown_req (shutdown_req),
        .sysreset_req (sysreset_req),
        .halt_req     (halt_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1;
        @(negedge clk);
        bus_wr    = 0;
        #1;
    endtask

    task automatic rd(input string req, input logic [31:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulses(input string req, input logic [2:0] exp);
        check(req, {29'd0, shutdown_req, sysreset_req, halt_req}, {29'd0, exp});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        rd("R1 cfg", 32'h0180_0000, 0);
        rd("R1 aux1", 32'h0190_0000, 0);
        rd("R1 aux2", 32'h0191_0000, 0);
        rd("R1 mdm", 32'h01b0_0000, 0);
        check("R1 irq", {31'd0, irq}, 0);
        pulses("R1 pulses", 3'b000);

        for (int i = 0; i < NV; i++) begin
            if (V_WR[i]) begin
                wr(V_AD[i], V_DA[i]);
            end else begin
                rd($sformatf("R%0d vector %0d", V_RQ[i], i), V_AD[i], V_EX[i]);
            end
        end

        // R4 write with command bits to unmapped space: no pulse
        wr(32'h0170_0000, 32'hFFFF_FFFF);
        pulses("R4 no pulse", 3'b000);
        // R9 command at a non-zero sub offset is ignored
        wr(32'h01f0_0002, 32'h1);
        pulses("R9 sub offset no pulse", 3'b000);
        rd("R9 sub offset keeps value", 32'h01f0_0000, 32'hF0);

        // R11 retention through reset
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        #1;
        rd("R11 diag", 32'h01a0_0000, 32'hC3);
        rd("R11 led", 32'h0160_0000, 32'h5678);
        rd("R11 sys", 32'h01f0_0000, 32'hF0);
        rd("R1 cfg after reset", 32'h0180_0000, 0);

        // R5 / R6 power fail with enable set
        wr(32'h0180_0000, 32'h08);
        @(negedge clk);
        pwr_failing = 1;
        @(negedge clk);
        #1;
        rd("R5 flag set", 32'h0191_0000, 32'h20);
        check("R6 irq high", {31'd0, irq}, 1);
        wr(32'h0180_0000, 32'h00);
        check("R6 irq drops with enable", {31'd0, irq}, 0);
        rd("R5 flag kept on cfg write", 32'h0191_0000, 32'h20);
        wr(32'h0180_0000, 32'h08);
        check("R6 irq back", {31'd0, irq}, 1);

        // R7 software clear while input stays high
        wr(32'h0191_0000, 32'h02);
        rd("R7 cleared", 32'h0191_0000, 32'h02);
        check("R7 irq low", {31'd0, irq}, 0);
        repeat (3) @(negedge clk);
        #1;
        rd("R7 stays clear", 32'h0191_0000, 32'h02);
        @(negedge clk);
        pwr_failing = 0;
        @(negedge clk);
        #1;
        rd("R5 input low", 32'h0191_0000, 32'h02);

        // R5 gated by enable
        wr(32'h0180_0000, 32'h00);
        @(negedge clk);
        pwr_failing = 1;
        @(negedge clk);
        #1;
        rd("R5 gated", 32'h0191_0000, 32'h02);
        check("R6 gated irq", {31'd0, irq}, 0);

        // R8 shutdown
        wr(32'h0191_0000, 32'h01);
        pulses("R8 shutdown pulse", 3'b100);
        rd("R7 aux2 cmd bits", 32'h0191_0000, 32'h01);
        @(negedge clk);
        #1;
        pulses("R8 shutdown ends", 3'b000);

        // R9 system reset
        wr(32'h01f0_0000, 32'h0000_00F1);
        pulses("R9 reset pulse", 3'b010);
        rd("R9 status value", 32'h01f0_0000, 32'h2);
        @(negedge clk);
        #1;
        pulses("R9 reset ends", 3'b000);

        // R10 halt
        wr(PM, 32'h0);
        pulses("R10 halt pulse", 3'b001);
        @(negedge clk);
        #1;
        pulses("R10 halt ends", 3'b000);
        rd("R10 read zero", PM, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule